// File: doc/BRIEF.md
# Programmable Reference Divider with Phase-Frequency Detector

This block sits in the reference path of a frequency synthesizer. A crystal clock drives a down-counter that emits one clock-wide pulse every `ratio_i` clocks. That pulse sets the comparison rate. The divided pulse is compared with a feedback pulse coming from the loop's main divider. A two-state phase-frequency detector raises a pump-up or pump-down request for the time between the two events.

A static sense bit picks which request drives which output. This lets one loop design serve oscillators whose frequency rises with control voltage and oscillators whose frequency falls with it.

The feedback pulse must be synchronous to the reference clock. The ratio may change at any time; the count already in progress finishes first. The analog pump, the loop filter and any lock indication are outside this block.

Top module: `refpfd_top`

## Requirements
- R1: For a ratio between 3 and 32767, `div_pulse_o` goes high exactly once every `ratio_i` clock cycles.
- R2: A ratio of 0, 1 or 2 is handled as if it were 3, so the pulse interval is 3 cycles.
- R3: While `rst_ni` is low, `up_o`, `dn_o` and `div_pulse_o` are all low. The first divided pulse is visible in the first cycle after the first rising clock edge following release.
- R4: A ratio change takes effect only when the count reloads. The interval already running completes with the old ratio, and the interval after it uses the new one.
- R5: `div_pulse_o` is never high for two consecutive cycles.
- R6: With `invert_i` = 0, a divided pulse followed d cycles later by a feedback pulse (d ≥ 1) makes `up_o` high for exactly d cycles, beginning the cycle after the divided pulse. `dn_o` stays low.
- R7: With `invert_i` = 0, a feedback pulse that arrives while no request is pending raises `dn_o`. `dn_o` stays high until the cycle after the next divided pulse, and `up_o` stays low.
- R8: A feedback pulse in the same cycle as the divided pulse, with nothing pending, raises neither output.
- R9: With `invert_i` = 1, the requests described in R6 and R7 appear on the opposite outputs: a lagging feedback pulse raises `dn_o` and a leading one raises `up_o`.
- R10: `up_o` and `dn_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference (crystal) clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | 15 | Reference division ratio |
| invert_i | input | 1 | Detector sense: 0 positive slope, 1 negative slope |
| fb_i | input | 1 | Feedback pulse from main divider, one clock wide |
| up_o | output | 1 | Pump-up request |
| dn_o | output | 1 | Pump-down request |
| div_pulse_o | output | 1 | Divided reference pulse |

## Verification
The divider is driven with ratios of 3, 5 and 64, with the largest legal ratio, and with the three illegal low ratios. These runs separate a correct reload value from an off-by-one error and show whether the clamp is present. A ratio change in the middle of an interval shows whether the reload samples the ratio only at terminal count.

The detector is driven with three feedback placements: lagging the divided pulse by three cycles, coincident with it, and leading it by two cycles after a coincident cycle has cleared all state. The request widths measured at the ports tell a correct set/clear path apart from one that misses an event or clears late. Repeating the lag and lead cases with the sense bit set shows that the outputs are exchanged and not merely gated.

// File: rtl/refpfd_pkg.sv
package refpfd_pkg;
  localparam int unsigned RATIO_W   = 15;
  localparam int unsigned RATIO_MIN = 3;

  typedef struct packed {
    logic up;
    logic dn;
  } pfd_req_t;
endpackage

// File: rtl/refpfd_divider.sv
module refpfd_divider #(
  parameter int unsigned W    = refpfd_pkg::RATIO_W,
  parameter int unsigned MINR = refpfd_pkg::RATIO_MIN
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ratio_i,
  output logic         tick_o
);
  localparam logic [W-1:0] MIN_V = W'(MINR);

  logic [W-1:0] cnt_q;
  logic [W-1:0] load_v;
  logic         tick_q;
  logic         tc;

  assign tc = (cnt_q == '0);

  // illegal low ratios clamp to the minimum
  always_comb begin
    if (ratio_i < MIN_V) load_v = MIN_V - W'(1);
    else                 load_v = ratio_i - W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= tc;
      if (tc) cnt_q <= load_v;
      else    cnt_q <= cnt_q - W'(1);
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/refpfd_detector.sv
module refpfd_detector
  import refpfd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ref_ev_i,
  input  logic     fb_ev_i,
  output pfd_req_t req_o
);
  pfd_req_t req_q, req_d;
  logic     set_up, set_dn;

  always_comb begin
    set_up = req_q.up | ref_ev_i;
    set_dn = req_q.dn | fb_ev_i;
    // both edges seen: clear in the same step, no overlap cycle
    req_d.up = set_up & ~set_dn;
    req_d.dn = set_dn & ~set_up;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_d;
  end

  assign req_o = req_q;
endmodule

// File: rtl/refpfd_sense.sv
module refpfd_sense
  import refpfd_pkg::*;
(
  input  logic     invert_i,
  input  pfd_req_t req_i,
  output logic     up_o,
  output logic     dn_o
);
  always_comb begin
    if (invert_i) begin
      up_o = req_i.dn;
      dn_o = req_i.up;
    end else begin
      up_o = req_i.up;
      dn_o = req_i.dn;
    end
  end
endmodule

// File: rtl/refpfd_top.sv
module refpfd_top
  import refpfd_pkg::*;
#(
  parameter int unsigned W = RATIO_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ratio_i,
  input  logic         invert_i,
  input  logic         fb_i,
  output logic         up_o,
  output logic         dn_o,
  output logic         div_pulse_o
);
  logic     tick;
  pfd_req_t req;

  refpfd_divider #(.W(W), .MINR(RATIO_MIN)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ratio_i(ratio_i),
    .tick_o (tick)
  );

  refpfd_detector u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ref_ev_i(tick),
    .fb_ev_i (fb_i),
    .req_o   (req)
  );

  refpfd_sense u_sense (
    .invert_i(invert_i),
    .req_i   (req),
    .up_o    (up_o),
    .dn_o    (dn_o)
  );

  assign div_pulse_o = tick;
endmodule

// File: rtl/refpfd_checker.sv
module refpfd_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic invert_i,
  input logic fb_i,
  input logic up_o,
  input logic dn_o,
  input logic div_pulse_o
);
  assert_no_overlap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && dn_o));

  assert_pulse_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_pulse_o |=> !div_pulse_o);

  assert_ref_lead_up_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_pulse_o && !fb_i && !dn_o && !invert_i) |=> (up_o || invert_i));

  assert_fb_lead_dn_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_i && !div_pulse_o && !up_o && !invert_i) |=> (dn_o || invert_i));

  assert_coincide_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_i && div_pulse_o && !up_o && !dn_o) |=> (!up_o && !dn_o));

  assert_inverted_lag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_pulse_o && !fb_i && !up_o && invert_i) |=> (dn_o || !invert_i));
endmodule

bind refpfd_top refpfd_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .invert_i   (invert_i),
  .fb_i       (fb_i),
  .up_o       (up_o),
  .dn_o       (dn_o),
  .div_pulse_o(div_pulse_o)
);

// File: tb/refpfd_top_tb.sv
module refpfd_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 40000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [14:0] ratio = 15'd5;
  logic        invert = 1'b0;
  logic        fb = 1'b0;
  logic        up, dn, pulse;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refpfd_top u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .ratio_i    (ratio),
    .invert_i   (invert),
    .fb_i       (fb),
    .up_o       (up),
    .dn_o       (dn),
    .div_pulse_o(pulse)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    fb = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check("R3 reset up", int'(up), 0);
    check("R3 reset dn", int'(dn), 0);
    check("R3 reset pulse", int'(pulse), 0);
    rst_ni = 1'b1;
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pulse && n < LIMIT);
    if (!pulse) check("pulse timeout", n, -1);
  endtask

  task automatic t_first_pulse();
    int n;
    ratio = 15'd5;
    do_reset();
    wait_pulse(n);
    check("R3 first pulse delay", n, 1);
    @(negedge clk);
    check("R5 pulse width", int'(pulse), 0);
  endtask

  task automatic t_period(input int r, input int exp, input string req);
    int n;
    ratio = 15'(r);
    do_reset();
    wait_pulse(n);
    for (int k = 0; k < 2; k++) begin
      wait_pulse(n);
      check(req, n, exp);
    end
  endtask

  task automatic t_period_once(input int r, input string req);
    int n;
    ratio = 15'(r);
    do_reset();
    wait_pulse(n);
    wait_pulse(n);
    check(req, n, r);
  endtask

  task automatic t_ratio_change();
    int n;
    ratio = 15'd10;
    do_reset();
    wait_pulse(n);
    repeat (2) @(negedge clk);
    ratio = 15'd4;
    wait_pulse(n);
    check("R4 interval after change uses old ratio", n + 2, 10);
    wait_pulse(n);
    check("R4 next interval uses new ratio", n, 4);
  endtask

  // fb pulses at offsets fa/fb2 after the divided pulse; -1 = unused
  task automatic t_phase(input int r, input bit inv, input int fa, input int fb2,
                         input int exp_up, input int exp_dn, input string req);
    int n, ups, dns, both;
    ratio = 15'(r);
    invert = inv;
    do_reset();
    wait_pulse(n);
    ups = 0; dns = 0; both = 0;
    for (int i = 0; i < r; i++) begin
      fb = (i == fa) || (i == fb2);
      @(negedge clk);
      ups += int'(up);
      dns += int'(dn);
      if (up && dn) both++;
    end
    fb = 1'b0;
    check({req, " up cycles"}, ups, exp_up);
    check({req, " dn cycles"}, dns, exp_dn);
    check("R10 no overlap", both, 0);
    invert = 1'b0;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    t_first_pulse();
    t_period(5, 5, "R1 period ratio 5");
    t_period(3, 3, "R1 period ratio 3");
    t_period(64, 64, "R1 period ratio 64");
    t_period_once(32767, "R1 period ratio max");
    t_period(0, 3, "R2 ratio 0 clamps");
    t_period(1, 3, "R2 ratio 1 clamps");
    t_period(2, 3, "R2 ratio 2 clamps");
    t_ratio_change();
    t_phase(8, 1'b0, 3, -1, 3, 0, "R6 ref leads");
    t_phase(8, 1'b0, 0, 6, 0, 2, "R7 fb leads");
    t_phase(8, 1'b0, 0, -1, 0, 0, "R8 coincident");
    t_phase(8, 1'b1, 3, -1, 0, 3, "R9 inverted ref leads");
    t_phase(8, 1'b1, 0, 6, 2, 0, "R9 inverted fb leads");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule